// File: doc/BRIEF.md
# Byte/Word Data Bus Adapter

This block joins an external 16-bit flash-style data and address bus to a fixed 16-bit internal word path. A width-select pin chooses the mode. When the pin is high the bus is a full word bus: all sixteen data lines carry data in both directions. When the pin is low the bus is a byte bus. The topmost data line then stops carrying data and becomes an extra least-significant address input. That input picks the byte lane of the internal word. The lines between the low byte and the top line are not driven.

Command cycles are always one byte wide, in either mode. The command byte comes from the low eight data lines, and the upper lines play no part in it. The adapter registers the internal address, write data, byte enables, write strobes and command byte one cycle after the bus cycle. The read data and the three output-enable groups follow one cycle later. That extra cycle exists because the internal array answers the registered address. The array and the decoding of commands sit outside this block.

Top module: `bwa_top`

## Requirements
- R1: While reset is held and right after it, every output is zero, so all three output-enable groups are off.
- R2: In word mode (width_sel=1), a read cycle presents the full internal word on pin_dout two clock edges after the cycle, with pin_oe_lo, pin_oe_mid and pin_oe_top all asserted.
- R3: In byte mode (width_sel=0), a read cycle puts the low byte of the internal word on pin_dout[7:0] when pin_din[15] is 0, and the high byte when it is 1. pin_dout[15:8] is zero.
- R4: During a byte-mode read, pin_oe_lo is on while pin_oe_mid (lines 8..14) and pin_oe_top (line 15) stay off.
- R5: One edge after a bus cycle, core_addr equals {word_addr, pin_din[15]} in byte mode and {word_addr, 0} in word mode.
- R6: A word-mode data write (bus_wr=1, bus_cmd=0) gives core_we=1, core_wbe=2'b11 and core_wdata=pin_din one edge later.
- R7: A byte-mode data write gives core_we=1 and core_wdata={pin_din[7:0], pin_din[7:0]}. core_wbe is 2'b01 when pin_din[15]=0 and 2'b10 when it is 1.
- R8: A command write (bus_wr=1, bus_cmd=1), in either mode, gives cmd_we=1 and cmd_byte=pin_din[7:0] one edge later, with core_we=0. pin_din[15:8] has no effect on cmd_byte.
- R9: When no read occurred two edges earlier, all output-enable groups are off and pin_dout is zero. core_we and cmd_we are high only for the one edge after their write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| width_sel | input | 1 | 1 = word bus, 0 = byte bus |
| bus_rd | input | 1 | Read cycle this clock |
| bus_wr | input | 1 | Write cycle this clock |
| bus_cmd | input | 1 | Write cycle is a command cycle |
| word_addr | input | AW | External word address lines |
| pin_din | input | DW | Values sampled on the data pins |
| core_rdata | input | DW | Word returned by the internal array for core_addr |
| pin_dout | output | DW | Values to drive on the data pins |
| pin_oe_lo | output | 1 | Drive enable, data lines 0..7 |
| pin_oe_mid | output | 1 | Drive enable, data lines 8..14 |
| pin_oe_top | output | 1 | Drive enable, data line 15 |
| core_addr | output | AW+1 | Internal byte address |
| core_wdata | output | DW | Internal write word |
| core_wbe | output | 2 | Internal byte enables, bit 1 = high byte |
| core_we | output | 1 | Internal data write strobe |
| cmd_we | output | 1 | Command byte strobe |
| cmd_byte | output | DW/2 | Command byte |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle, that bus_cmd matters only together with bus_wr, and that width_sel stays steady for the length of each bus cycle. The bench holds each cycle's inputs for one clock, between falling edges, and returns every control to idle before starting the next cycle. It sweeps every mode, word address, lane bit and operation kind of a small address width. During command writes it varies the upper data lines so that their lack of effect can be seen.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
    // Drive-enable groups of the data pins.
    typedef struct packed {
        logic lo;
        logic mid;
        logic top;
    } oe_grp_t;

    localparam int unsigned LANES = 2;
endpackage

// File: rtl/bwa_addr_map.sv
module bwa_addr_map #(
    parameter int unsigned AW = 8
) (
    input  logic          byte_mode,
    input  logic [AW-1:0] word_addr,
    input  logic          addr_lsb,
    output logic [AW:0]   core_addr,
    output logic          lane
);
    // The lane comes from the repurposed pin in byte mode and is zero otherwise.
    always_comb begin
        lane      = byte_mode & addr_lsb;
        core_addr = {word_addr, lane};
    end
endmodule

// File: rtl/bwa_lane_steer.sv
module bwa_lane_steer
    import bwa_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic             wr_byte,
    input  logic             wr_lane,
    input  logic [DW-1:0]    pin_din,
    input  logic             rd_byte,
    input  logic             rd_lane,
    input  logic [DW-1:0]    rdata,
    output logic [DW-1:0]    wdata,
    output logic [LANES-1:0] wbe,
    output logic [DW-1:0]    rd_pins
);
    localparam int unsigned LW = DW / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            wbe[g]             = !wr_byte || (wr_lane == g[0]);
            wdata[g*LW +: LW]  = wr_byte ? pin_din[LW-1:0] : pin_din[g*LW +: LW];
        end
    end

    always_comb begin
        if (rd_byte) begin
            rd_pins[LW-1:0]  = rd_lane ? rdata[DW-1:LW] : rdata[LW-1:0];
            rd_pins[DW-1:LW] = '0;
        end else begin
            rd_pins = rdata;
        end
    end
endmodule

// File: rtl/bwa_top.sv
module bwa_top
    import bwa_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            width_sel,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic            bus_cmd,
    input  logic [AW-1:0]   word_addr,
    input  logic [DW-1:0]   pin_din,
    input  logic [DW-1:0]   core_rdata,
    output logic [DW-1:0]   pin_dout,
    output logic            pin_oe_lo,
    output logic            pin_oe_mid,
    output logic            pin_oe_top,
    output logic [AW:0]     core_addr,
    output logic [DW-1:0]   core_wdata,
    output logic [1:0]      core_wbe,
    output logic            core_we,
    output logic            cmd_we,
    output logic [DW/2-1:0] cmd_byte
);
    localparam int unsigned LW = DW / LANES;

    typedef struct packed {
        logic             rd;
        logic             byte_m;
        logic             lane;
        logic [AW:0]      addr;
        logic [DW-1:0]    wdata;
        logic [LANES-1:0] wbe;
        logic             we;
        logic             cwe;
        logic [LW-1:0]    cmd;
        logic [DW-1:0]    dout;
        oe_grp_t          oe;
    } st_t;

    st_t st_d, st_q;

    logic             byte_in;
    logic             lane_in;
    logic [AW:0]      addr_in;
    logic [DW-1:0]    wdata_in;
    logic [LANES-1:0] wbe_in;
    logic [DW-1:0]    rd_pins;

    assign byte_in = !width_sel;

    bwa_addr_map #(.AW(AW)) u_map (
        .byte_mode (byte_in),
        .word_addr (word_addr),
        .addr_lsb  (pin_din[DW-1]),
        .core_addr (addr_in),
        .lane      (lane_in)
    );

    bwa_lane_steer #(.DW(DW)) u_steer (
        .wr_byte (byte_in),
        .wr_lane (lane_in),
        .pin_din (pin_din),
        .rd_byte (st_q.byte_m),
        .rd_lane (st_q.lane),
        .rdata   (core_rdata),
        .wdata   (wdata_in),
        .wbe     (wbe_in),
        .rd_pins (rd_pins)
    );

    always_comb begin
        st_d        = st_q;
        // stage 1: capture the bus cycle
        st_d.rd     = bus_rd && !bus_wr;
        st_d.byte_m = byte_in;
        st_d.lane   = lane_in;
        st_d.addr   = addr_in;
        st_d.we     = bus_wr && !bus_cmd;
        st_d.cwe    = bus_wr && bus_cmd;
        st_d.wbe    = (bus_wr && !bus_cmd) ? wbe_in : '0;
        if (bus_wr && !bus_cmd) begin
            st_d.wdata = wdata_in;
        end
        if (bus_wr && bus_cmd) begin
            st_d.cmd = pin_din[LW-1:0];
        end
        // stage 2: return data and pin drive enables
        st_d.dout   = st_q.rd ? rd_pins : '0;
        st_d.oe.lo  = st_q.rd;
        st_d.oe.mid = st_q.rd && !st_q.byte_m;
        st_d.oe.top = st_q.rd && !st_q.byte_m;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_dout   = st_q.dout;
    assign pin_oe_lo  = st_q.oe.lo;
    assign pin_oe_mid = st_q.oe.mid;
    assign pin_oe_top = st_q.oe.top;
    assign core_addr  = st_q.addr;
    assign core_wdata = st_q.wdata;
    assign core_wbe   = st_q.wbe;
    assign core_we    = st_q.we;
    assign cmd_we     = st_q.cwe;
    assign cmd_byte   = st_q.cmd;

    assert_byte_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rd && st_q.byte_m) |=> (pin_oe_lo && !pin_oe_mid && !pin_oe_top));

    assert_no_read_no_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.rd |=> (!pin_oe_lo && !pin_oe_mid && !pin_oe_top));

    assert_cmd_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_we && cmd_we));

    assert_cmd_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |-> (cmd_byte == $past(pin_din[LW-1:0])));

    assert_byte_wbe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_we && !$past(width_sel)) |-> ($countones(core_wbe) == 1));

    assert_word_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(width_sel) |-> (core_addr[0] == 1'b0));
endmodule

// File: tb/test_bwa_top.sv
module test_bwa_top;
    localparam int unsigned AW    = 3;
    localparam int unsigned DW    = 16;
    localparam int          CLK_P = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            width_sel, bus_rd, bus_wr, bus_cmd;
    logic [AW-1:0]   word_addr;
    logic [DW-1:0]   pin_din, core_rdata, pin_dout, core_wdata;
    logic            pin_oe_lo, pin_oe_mid, pin_oe_top;
    logic [AW:0]     core_addr;
    logic [1:0]      core_wbe;
    logic            core_we, cmd_we;
    logic [DW/2-1:0] cmd_byte;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    // array model: word content derived from the word index
    function automatic logic [15:0] arr_word(input logic [AW:0] a);
        logic [7:0] idx;
        idx = 8'(a >> 1);
        return {8'(idx * 8'd3 + 8'h40), 8'(idx * 8'd5 + 8'h11)};
    endfunction
    assign core_rdata = arr_word(core_addr);

    bwa_top #(.AW(AW), .DW(DW)) i_bwa_top (
        .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_cmd(bus_cmd), .word_addr(word_addr),
        .pin_din(pin_din), .core_rdata(core_rdata), .pin_dout(pin_dout),
        .pin_oe_lo(pin_oe_lo), .pin_oe_mid(pin_oe_mid), .pin_oe_top(pin_oe_top),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_wbe(core_wbe),
        .core_we(core_we), .cmd_we(cmd_we), .cmd_byte(cmd_byte)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_rd = 0; bus_wr = 0; bus_cmd = 0;
    endtask

    task automatic do_read(input logic wsel, input int a, input logic lsb);
        logic [15:0] w;
        logic [15:0] exp_d;
        width_sel = wsel; word_addr = AW'(a);
        pin_din = {lsb, 15'h0}; bus_rd = 1;
        @(negedge clk); idle();
        chk("R5 addr", 32'(core_addr), wsel ? 32'(a << 1) : 32'((a << 1) | int'(lsb)));
        chk("R9 oe off stage1", {pin_oe_lo, pin_oe_mid, pin_oe_top}, 0);
        w = arr_word(AW'(a) << 1);
        if (wsel) exp_d = w;
        else      exp_d = lsb ? {8'h0, w[15:8]} : {8'h0, w[7:0]};
        @(negedge clk);
        if (wsel) begin
            chk("R2 word data", 32'(pin_dout), 32'(exp_d));
            chk("R2 word oe", {pin_oe_lo, pin_oe_mid, pin_oe_top}, 3'b111);
        end else begin
            chk("R3 byte data", 32'(pin_dout), 32'(exp_d));
            chk("R4 byte oe", {pin_oe_lo, pin_oe_mid, pin_oe_top}, 3'b100);
        end
        @(negedge clk);
        chk("R9 oe off after", {pin_oe_lo, pin_oe_mid, pin_oe_top, 16'(pin_dout)}, 0);
    endtask

    task automatic do_write(input logic wsel, input int a, input logic lsb, input logic [14:0] d);
        width_sel = wsel; word_addr = AW'(a);
        pin_din = {lsb, d}; bus_wr = 1; bus_cmd = 0;
        @(negedge clk); idle();
        if (wsel) begin
            chk("R6 we", {core_we, cmd_we}, 2'b10);
            chk("R6 wbe", core_wbe, 2'b11);
            chk("R6 wdata", 32'(core_wdata), 32'({lsb, d}));
        end else begin
            chk("R7 we", {core_we, cmd_we}, 2'b10);
            chk("R7 wbe", core_wbe, lsb ? 2'b10 : 2'b01);
            chk("R7 wdata", 32'(core_wdata), 32'({d[7:0], d[7:0]}));
            chk("R5 byte addr", 32'(core_addr), 32'((a << 1) | int'(lsb)));
        end
        @(negedge clk);
        chk("R9 we pulse", {core_we, cmd_we}, 2'b00);
    endtask

    task automatic do_cmd(input logic wsel, input logic [7:0] c, input logic [7:0] up);
        width_sel = wsel; word_addr = '0;
        pin_din = {up, c}; bus_wr = 1; bus_cmd = 1;
        @(negedge clk); idle();
        chk("R8 strobes", {core_we, cmd_we}, 2'b01);
        chk("R8 cmd byte", 32'(cmd_byte), 32'(c));
        chk("R8 no wbe", core_wbe, 2'b00);
        @(negedge clk);
        chk("R9 cmd pulse", cmd_we, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; width_sel = 1; word_addr = '0; pin_din = '0; idle();
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {pin_oe_lo, pin_oe_mid, pin_oe_top, core_we, cmd_we, core_wbe},
            0);
        chk("R1 reset data", {16'(pin_dout), 16'(core_wdata)}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset", {pin_oe_lo, 8'(cmd_byte), 4'(core_addr)}, 0);
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < (1 << AW); a++) begin
                for (int l = 0; l < 2; l++) begin
                    do_read(m[0], a, l[0]);
                    do_write(m[0], a, l[0], 15'(16'h1357 * (a + 1) + l * 16'h0a5));
                end
            end
            for (int c = 0; c < 256; c += 17) begin
                do_cmd(m[0], 8'(c), 8'h00);
                do_cmd(m[0], 8'(c), 8'(8'hff - c));
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule